// File: doc/BRIEF.md
# BLDC Commutation Output Gating

This block sits between a three-phase PWM generator and the six gate-drive outputs of a brushless DC motor bridge: three high-side pins and three low-side pins. It decides which pins are active for the current commutation step. The step comes from one of two sources. The first is three Hall-sensor feedback inputs, which are synchronized first. The second is three phase bits written by software into an 8-bit control register.

An active pin drives either a static on-level or the incoming PWM waveform for that pin. The high side and the low side make this choice independently. A pin that is not selected is held at logic 0. Gating is applied only when the control register enables it and the timer reports a PWM mode in which gating is meaningful. At all other times the six PWM inputs pass straight through to the outputs.

Phase bit order is the same everywhere: index 0 is phase U, index 1 is phase V and index 2 is phase W. A commutation pattern is written {W,V,U}.

Top module: `bldc_gate_top`

## Requirements
- R1: After reset, rd_data reads 8'h80. The gating is disabled, so all outputs follow the PWM inputs.
- R2: A write with wr_en high stores wr_data[6:0], which reads back from the next cycle. rd_data[7] always reads 1, whatever value is written to it.
- R3: With control bit 6 (gate enable) at 0, drv_hi_out equals pwm_hi_in and drv_lo_out equals pwm_lo_in.
- R4: With pwm_mode_ok low, the outputs equal the PWM inputs, whatever the control register holds.
- R5: When gating is active, the pattern {W,V,U} selects one high-side pin and one low-side pin as follows:
  - 001 selects U-high and V-low.
  - 011 selects U-high and W-low.
  - 010 selects V-high and W-low.
  - 110 selects V-high and U-low.
  - 100 selects W-high and U-low.
  - 101 selects W-high and V-low.
  - Every pin that is not selected drives 0.
- R6: When gating is active, the patterns 000 and 111 drive all six outputs to 0.
- R7: Control bit 4 sets the high side: 0 drives 1 on the selected high pin, and 1 drives that pin's pwm_hi_in bit.
- R8: Control bit 5 sets the low side: 0 drives 1 on the selected low pin, and 1 drives that pin's pwm_lo_in bit.
- R9: Control bit 3 sets the step source: 0 uses hall_in, and 1 uses control bits 2:0 as {W,V,U}.
  - A change on hall_in reaches the outputs on the third rising edge after it.
  - A write to the phase bits reaches the outputs one edge after the write edge.
  - Changes to the gate enable, the level bits and pwm_mode_ok, and changes on the PWM inputs, act without a clock.
- R10: While bit 3 is 1, changes on hall_in have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register readback |
| pwm_mode_ok | input | 1 | High when the timer is in a PWM mode where gating applies |
| hall_in | input | 3 | Hall feedback {W,V,U}, asynchronous |
| pwm_hi_in | input | 3 | High-side PWM waveforms {W,V,U} |
| pwm_lo_in | input | 3 | Low-side PWM waveforms {W,V,U} |
| drv_hi_out | output | 3 | High-side drive outputs {W,V,U} |
| drv_lo_out | output | 3 | Low-side drive outputs {W,V,U} |

## Verification
Results arrive at three different times:

- **Pass-through and levels.** The pass-through path and the static-or-PWM choice on each side are combinational. They are checked shortly after the edge on which the register write or input change lands.
- **Software pattern.** A new software pattern appears one edge after its write edge.
- **Hall pattern.** A new Hall pattern appears on the third edge after it changes.

The latency cases sample one edge early and expect the old outputs, then sample on the due edge and expect the new ones. Every other case holds its stimulus for three edges before it samples. All inputs are driven and all outputs sampled 1 ns after a rising edge, well away from the next one.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;

   localparam int unsigned CFG_W = 8;
   localparam int unsigned NPH   = 3;

   typedef struct packed {
      logic            rsvd;
      logic            gate_en;
      logic            lo_pwm;
      logic            hi_pwm;
      logic            sw_src;
      logic [NPH-1:0]  sw_pat;
   } gate_cfg_t;

   typedef struct packed {
      logic [NPH-1:0] hi;
      logic [NPH-1:0] lo;
   } gate_sel_t;

   // Six-step table, pattern is {W,V,U}, index 0 = U
   function automatic gate_sel_t step_lookup(input logic [NPH-1:0] pat);
      gate_sel_t s;
      case (pat)
         3'b001:  s = '{hi: 3'b001, lo: 3'b010};
         3'b011:  s = '{hi: 3'b001, lo: 3'b100};
         3'b010:  s = '{hi: 3'b010, lo: 3'b100};
         3'b110:  s = '{hi: 3'b010, lo: 3'b001};
         3'b100:  s = '{hi: 3'b100, lo: 3'b001};
         3'b101:  s = '{hi: 3'b100, lo: 3'b010};
         default: s = '{hi: 3'b000, lo: 3'b000};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/bldc_ctrl_reg.sv
module bldc_ctrl_reg
   import bldc_gate_pkg::*;
#(
   parameter int unsigned REG_W = CFG_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output gate_cfg_t        cfg_o
);

   localparam int unsigned STORE_W = REG_W - 1;

   generate
      if (REG_W != $bits(gate_cfg_t)) begin : g_bad_width
         $error("bldc_ctrl_reg: REG_W must match the control layout");
      end
   endgenerate

   logic [STORE_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     store_q <= '0;
      else if (wr_en) store_q <= wr_data[STORE_W-1:0];
   end

   assign cfg_o = gate_cfg_t'({1'b1, store_q});

   // R2
   wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg_o[STORE_W-1:0] == $past(wr_data[STORE_W-1:0])));

endmodule

// File: rtl/bldc_hall_sync.sv
module bldc_hall_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bldc_hall_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= async_i;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[k] <= '0;
         else        chain_q[k] <= chain_q[k-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

   // R9
   sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sync_o) |-> (sync_o == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/bldc_step_select.sv
module bldc_step_select
   import bldc_gate_pkg::*;
#(
   parameter bit REG_DECODE = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_src,
   input  logic [NPH-1:0]  sw_pat,
   input  logic [NPH-1:0]  hall_pat,
   output gate_sel_t       sel_o
);

   logic [NPH-1:0] pat;
   gate_sel_t      sel_d;

   assign pat   = sw_src ? sw_pat : hall_pat;
   assign sel_d = step_lookup(pat);

   generate
      if (REG_DECODE) begin : g_reg
         gate_sel_t sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= '0;
            else        sel_q <= sel_d;
         end
         assign sel_o = sel_q;

         // R9
         sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pat == $past(pat)) |=> $stable(sel_o));
      end else begin : g_comb
         assign sel_o = sel_d;
      end
   endgenerate

   // R5
   hi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o.hi));
   // R5
   lo_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o.lo));
   // R5
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o.hi & sel_o.lo) == '0);

endmodule

// File: rtl/bldc_gate_top.sv
module bldc_gate_top
   import bldc_gate_pkg::*;
#(
   parameter int unsigned PHASES       = 3,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          REG_DECODE   = 1'b1,
   parameter bit          ACTIVE_LEVEL = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_W-1:0]  wr_data,
   output logic [CFG_W-1:0]  rd_data,
   input  logic              pwm_mode_ok,
   input  logic [PHASES-1:0] hall_in,
   input  logic [PHASES-1:0] pwm_hi_in,
   input  logic [PHASES-1:0] pwm_lo_in,
   output logic [PHASES-1:0] drv_hi_out,
   output logic [PHASES-1:0] drv_lo_out
);

   localparam logic IDLE_LEVEL = ~ACTIVE_LEVEL;

   generate
      if (PHASES != NPH) begin : g_bad_phases
         $error("bldc_gate_top: six-step commutation needs PHASES == 3");
      end
   endgenerate

   gate_cfg_t      cfg;
   gate_sel_t      sel;
   logic [NPH-1:0] hall_s;
   logic           gate_act;

   bldc_ctrl_reg #(.REG_W(CFG_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cfg_o   (cfg)
   );

   bldc_hall_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (hall_in),
      .sync_o  (hall_s)
   );

   bldc_step_select #(.REG_DECODE(REG_DECODE)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_src   (cfg.sw_src),
      .sw_pat   (cfg.sw_pat),
      .hall_pat (hall_s),
      .sel_o    (sel)
   );

   assign rd_data  = cfg;
   assign gate_act = cfg.gate_en & pwm_mode_ok;

   for (genvar i = 0; i < PHASES; i++) begin : g_phase
      always_comb begin
         if (!gate_act)        drv_hi_out[i] = pwm_hi_in[i];
         else if (!sel.hi[i])  drv_hi_out[i] = IDLE_LEVEL;
         else if (cfg.hi_pwm)  drv_hi_out[i] = pwm_hi_in[i];
         else                  drv_hi_out[i] = ACTIVE_LEVEL;

         if (!gate_act)        drv_lo_out[i] = pwm_lo_in[i];
         else if (!sel.lo[i])  drv_lo_out[i] = IDLE_LEVEL;
         else if (cfg.lo_pwm)  drv_lo_out[i] = pwm_lo_in[i];
         else                  drv_lo_out[i] = ACTIVE_LEVEL;
      end
   end

   // R5
   out_hi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_act |-> $onehot0(drv_hi_out ^ {PHASES{IDLE_LEVEL}}));
   // R5
   out_lo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_act |-> $onehot0(drv_lo_out ^ {PHASES{IDLE_LEVEL}}));
   // R2
   rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[CFG_W-1] == 1'b1);

endmodule

// File: tb/bldc_gate_top_tb_top.sv
`timescale 1ns/1ps
module bldc_gate_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       pwm_mode_ok = 1'b0;
   logic [2:0] hall_in = '0;
   logic [2:0] pwm_hi_in = '0;
   logic [2:0] pwm_lo_in = '0;
   logic [2:0] drv_hi_out;
   logic [2:0] drv_lo_out;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;
   logic [7:0] cfg_sh = 8'h80;

   always #2.5 clk = ~clk;

   bldc_gate_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_mode_ok(pwm_mode_ok), .hall_in(hall_in),
      .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
      .drv_hi_out(drv_hi_out), .drv_lo_out(drv_lo_out)
   );

   function automatic logic [5:0] step_ref(input logic [2:0] p);
      case (p)
         3'b001:  return 6'b001_010;
         3'b011:  return 6'b001_100;
         3'b010:  return 6'b010_100;
         3'b110:  return 6'b010_001;
         3'b100:  return 6'b100_001;
         3'b101:  return 6'b100_010;
         default: return 6'b000_000;
      endcase
   endfunction

   function automatic logic [5:0] out_ref(input logic [7:0] c, input logic m,
         input logic [2:0] h, input logic [2:0] ph, input logic [2:0] pl);
      logic [5:0] t;
      logic [2:0] p;
      if (!c[6] || !m) return {ph, pl};
      p = c[3] ? c[2:0] : h;
      t = step_ref(p);
      return {t[5:3] & (c[4] ? ph : 3'b111), t[2:0] & (c[5] ? pl : 3'b111)};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // write lands on the next edge; returns 1 ns after it
   task automatic reg_write(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      settle(1);
      wr_en   = 1'b0;
      cfg_sh  = {1'b1, d[6:0]};
   endtask

   function automatic logic [7:0] outs();
      return {2'b00, drv_hi_out, drv_lo_out};
   endfunction

   function automatic logic [7:0] model();
      return {2'b00, out_ref(cfg_sh, pwm_mode_ok, hall_in, pwm_hi_in, pwm_lo_in)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0B1D));
      pwm_hi_in = 3'b101;
      pwm_lo_in = 3'b010;
      pwm_mode_ok = 1'b1;
      settle(3);
      rst_n = 1'b1;
      settle(1);

      // R1 reset readback and pass-through
      check("R1", rd_data, 8'h80);
      check("R1", outs(), {2'b00, 3'b101, 3'b010});

      // R2 readback, reserved bit
      reg_write(8'h7F);
      check("R2", rd_data, 8'hFF);
      reg_write(8'h00);
      check("R2", rd_data, 8'h80);

      // R3 enable bit clear: pass-through even with a legal pattern
      reg_write(8'h39);
      settle(1);
      pwm_hi_in = 3'b011; pwm_lo_in = 3'b110;
      #1;
      check("R3", outs(), {2'b00, 3'b011, 3'b110});

      // sweep: sources, level bits, all patterns
      for (int src = 0; src < 2; src++) begin
         for (int lv = 0; lv < 4; lv++) begin
            for (int p = 0; p < 8; p++) begin
               logic [7:0] c;
               c = {1'b0, 1'b1, lv[1], lv[0], src[0], (src != 0) ? p[2:0] : 3'($urandom)};
               hall_in   = (src != 0) ? 3'($urandom) : p[2:0];
               pwm_hi_in = 3'($urandom);
               pwm_lo_in = 3'($urandom);
               reg_write(c);
               settle(3);
               if (p == 0 || p == 7) check("R6", outs(), model());
               else                  check("R5", outs(), model());
               check("R7", {5'b0, drv_hi_out}, {5'b0, model()[5:3]});
               check("R8", {5'b0, drv_lo_out}, {5'b0, model()[2:0]});
            end
         end
      end

      // R7 / R8 directed: PWM chopping follows the waveform bit
      reg_write(8'h79);
      settle(1);
      pwm_hi_in = 3'b001; pwm_lo_in = 3'b010; #1;
      check("R7", outs(), {2'b00, 3'b001, 3'b010});
      pwm_hi_in = 3'b110; pwm_lo_in = 3'b101; #1;
      check("R8", outs(), {2'b00, 3'b000, 3'b000});

      // R4 mode input low forces pass-through
      pwm_mode_ok = 1'b0; #1;
      check("R4", outs(), {2'b00, 3'b110, 3'b101});
      pwm_mode_ok = 1'b1;

      // R9 software latency: 001 -> 011
      reg_write(8'h49);
      settle(1);
      check("R9", outs(), {2'b00, 3'b001, 3'b010});
      reg_write(8'h4B);
      check("R9", outs(), {2'b00, 3'b001, 3'b010});
      settle(1);
      check("R9", outs(), {2'b00, 3'b001, 3'b100});
      // enable clear acts on the write edge
      pwm_hi_in = 3'b111; pwm_lo_in = 3'b000;
      reg_write(8'h0B);
      check("R9", outs(), {2'b00, 3'b111, 3'b000});

      // R9 Hall latency: 001 -> 010
      hall_in = 3'b001;
      reg_write(8'h40);
      settle(3);
      check("R9", outs(), {2'b00, 3'b001, 3'b010});
      hall_in = 3'b010;
      settle(2);
      check("R9", outs(), {2'b00, 3'b001, 3'b010});
      settle(1);
      check("R9", outs(), {2'b00, 3'b010, 3'b100});

      // R10 Hall ignored under software source
      reg_write(8'h4E);
      for (int h = 0; h < 8; h++) begin
         hall_in = h[2:0];
         settle(3);
         check("R10", outs(), {2'b00, 3'b010, 3'b001});
      end

      // random mix
      for (int it = 0; it < 300; it++) begin
         pwm_mode_ok = ($urandom % 5) != 0;
         hall_in     = 3'($urandom);
         pwm_hi_in   = 3'($urandom);
         pwm_lo_in   = 3'($urandom);
         reg_write(8'($urandom));
         settle(3);
         check("R5", outs(), model());
         check("R2", rd_data, cfg_sh);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule